// File: doc/BRIEF.md
# Instruction Latency Threshold Monitor

The block times marked instructions. A start pulse that comes with the marked qualifier opens a measurement, and the next end pulse closes it. The number of clock edges between the two pulses is reported as the latency. When the latency is above a programmed threshold, the block raises a one-cycle exceeded pulse. A performance-monitoring unit uses this pulse to catch instructions that run slower than expected.

The threshold comes from a configuration word in a compact base-4 floating form. The low `MANT_W` bits are a mantissa, and the `EXP_W` bits above them are an exponent. The cycle threshold is the mantissa shifted left by twice the exponent. The block decodes the word and captures the result at the start of each measurement, so software may rewrite the word while a measurement is in flight.

Every port is a plain control or status pin. The latency is a held value, not a stream. Nothing at the edge stalls, and there is no back-pressure to honour.

Top module: `lat_thr_mon`

## Requirements
- R1: A start pulse is accepted only when `marked` is high in the same cycle and no measurement is open. `busy` goes high on the next cycle. A start pulse without `marked` leaves `busy` low.
- R2: If the end pulse is sampled k rising edges after the accepted start, then in the cycle after the end pulse `latency` equals k and `busy` is low.
- R3: The cycle counter saturates at 2^CNT_W-1 instead of wrapping. A longer measurement reports that maximum value.
- R4: A start pulse that arrives while a measurement is open is ignored. The count is not restarted.
- R5: The mantissa is `thr_cfg[MANT_W-1:0]` and the exponent is `thr_cfg[MANT_W+EXP_W-1:MANT_W]`. The threshold in cycles is mantissa << (2*exponent).
- R6: An exponent above `MAX_EXP` decodes to the largest representable threshold, (2^MANT_W-1) << (2*MAX_EXP). With the default parameters this is 261120.
- R7: A configuration word with a nonzero exponent and both upper mantissa bits (bits 7:6 with the default width) at zero is invalid. It never produces an exceeded pulse.
- R8: A configuration word whose mantissa is zero disables the monitor. It never produces an exceeded pulse.
- R9: `exceed` is a single-cycle pulse. It is raised in the cycle after the end pulse, only when the latency is strictly greater than the threshold.
- R10: The threshold is captured when the start pulse is accepted. Changes to `thr_cfg` during the measurement do not affect its outcome.
- R11: `latency` holds its value until the next accepted start pulse. That pulse clears `latency` to zero on the following cycle.
- R12: An end pulse while no measurement is open is ignored. If start and end come in the same cycle while open, the end closes the measurement and the start is dropped. If they come in the same cycle while idle, the start opens a measurement and the end is dropped.
- R13: After reset, `busy`, `exceed` and `latency` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | Start event pulse |
| end_evt | input | 1 | End event pulse |
| marked | input | 1 | Qualifies the start pulse as belonging to a marked instruction |
| thr_cfg | input | MANT_W+EXP_W | Threshold word: exponent above, mantissa below |
| exceed | output | 1 | One-cycle pulse when the latency exceeded the threshold |
| latency | output | MANT_W+2*MAX_EXP | Latency of the last completed measurement |
| busy | output | 1 | A measurement is open |

## Verification
A start pulse and an end pulse can fall in the same cycle. The rule that resolves them depends on whether a measurement is already open. The bench provokes both cases. For the open case, it judges that the measurement closes with the full latency and that `busy` is low afterwards, which shows the start was dropped. For the idle case, it judges that `busy` rises and that a later end pulse reports the latency counted from that start. The bench also raises the configuration change and the end pulse close together. It checks that the exceeded decision follows the threshold captured at the start, not the word present at the end.

// File: rtl/lat_thr_pkg.sv
package lat_thr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } meas_state_e;

endpackage

// File: rtl/lat_thr_decode.sv
module lat_thr_decode #(
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  localparam int CNT_W  = MANT_W + 2 * MAX_EXP,
  localparam int CFG_W  = MANT_W + EXP_W
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] thr,
  output logic             armed
);

  localparam logic [CNT_W-1:0] MAX_THR =
    CNT_W'({MANT_W{1'b1}}) << (2 * MAX_EXP);

  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic [CNT_W-1:0]  cand [MAX_EXP+1];

  assign mant = cfg[MANT_W-1:0];
  assign expo = cfg[CFG_W-1:MANT_W];

  // one shifted copy per legal exponent
  for (genvar e = 0; e <= MAX_EXP; e++) begin : g_cand
    assign cand[e] = CNT_W'(mant) << (2 * e);
  end

  always_comb begin
    thr = MAX_THR;
    for (int e = 0; e <= MAX_EXP; e++) begin
      if (int'(expo) == e) thr = cand[e];
    end
  end

  // zero mantissa disables; nonzero exponent needs a top mantissa bit
  assign armed = (mant != '0) &&
                 !((expo != '0) && (mant[MANT_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/lat_thr_counter.sv
module lat_thr_counter #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             end_evt,
  input  logic             marked,
  output logic             open_meas,
  output logic             close_meas,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  import lat_thr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_state_e state_q;

  assign busy       = (state_q == ST_MEAS);
  assign open_meas  = !busy && start_evt && marked;
  assign close_meas = busy && end_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt     <= '0;
    end else if (open_meas) begin
      state_q <= ST_MEAS;
      cnt     <= CNT_W'(1);
    end else if (close_meas) begin
      state_q <= ST_IDLE;
    end else if (busy && cnt != CNT_MAX) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !end_evt && cnt == CNT_MAX |=> cnt == CNT_MAX);

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !end_evt |=> busy && cnt != CNT_W'(1));

  p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_evt && !marked |=> !busy);

endmodule

// File: rtl/lat_thr_mon.sv
module lat_thr_mon #(
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 5,
  localparam int CNT_W  = MANT_W + 2 * MAX_EXP,
  localparam int CFG_W  = MANT_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             end_evt,
  input  logic             marked,
  input  logic [CFG_W-1:0] thr_cfg,
  output logic             exceed,
  output logic [CNT_W-1:0] latency,
  output logic             busy
);

  logic [CNT_W-1:0] dec_thr;
  logic             dec_armed;
  logic             open_meas;
  logic             close_meas;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr_q;
  logic             armed_q;

  lat_thr_decode #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP)
  ) u_decode (
    .cfg  (thr_cfg),
    .thr  (dec_thr),
    .armed(dec_armed)
  );

  lat_thr_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .end_evt   (end_evt),
    .marked    (marked),
    .open_meas (open_meas),
    .close_meas(close_meas),
    .busy      (busy),
    .cnt       (cnt)
  );

  // threshold snapshot taken when a measurement opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      armed_q <= 1'b0;
    end else if (open_meas) begin
      thr_q   <= dec_thr;
      armed_q <= dec_armed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latency <= '0;
      exceed  <= 1'b0;
    end else begin
      exceed <= close_meas && armed_q && (cnt > thr_q);
      if (open_meas)       latency <= '0;
      else if (close_meas) latency <= cnt;
    end
  end

  p_exceed_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exceed |=> !exceed);

  p_exceed_strict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exceed |-> latency > thr_q);

  p_exceed_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exceed |-> armed_q);

  p_latency_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !open_meas && !close_meas |=> $stable(latency));

  p_idle_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && end_evt && !start_evt |=> !busy && !exceed);

endmodule

// File: tb/lat_thr_mon_bench.sv
module lat_thr_mon_bench;

  localparam int MANT_W  = 8;
  localparam int EXP_W   = 3;
  localparam int MAX_EXP = 2;
  localparam int CNT_W   = MANT_W + 2 * MAX_EXP;
  localparam int CFG_W   = MANT_W + EXP_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_evt = 1'b0;
  logic             end_evt = 1'b0;
  logic             marked = 1'b0;
  logic [CFG_W-1:0] thr_cfg = '0;
  logic             exceed;
  logic [CNT_W-1:0] latency;
  logic             busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int lat;
    bit exc;
    string req;
  } exp_item_t;

  exp_item_t sb[$];

  always #4 clk = ~clk;

  lat_thr_mon #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .MAX_EXP(MAX_EXP)
  ) u_lat_thr_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .end_evt  (end_evt),
    .marked   (marked),
    .thr_cfg  (thr_cfg),
    .exceed   (exceed),
    .latency  (latency),
    .busy     (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_thr(input logic [CFG_W-1:0] c);
    int e = int'(c[CFG_W-1:MANT_W]);
    int m = int'(c[MANT_W-1:0]);
    if (e > MAX_EXP) return 255 << (2 * MAX_EXP);
    return m << (2 * e);
  endfunction

  function automatic bit ref_armed(input logic [CFG_W-1:0] c);
    int e = int'(c[CFG_W-1:MANT_W]);
    int m = int'(c[MANT_W-1:0]);
    if (m == 0) return 1'b0;
    if (e != 0 && m < 64) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [CFG_W-1:0] mk(input int e, input int m);
    return {3'(e), 8'(m)};
  endfunction

  // Drive one measurement of k edges; push the expected outcome.
  // mode 0: plain, 1: extra start mid-run (R4), 2: start with end (R12),
  // 3: cfg rewritten mid-run to cfg_mid (R10)
  task automatic measure(input int k, input logic [CFG_W-1:0] cfg,
                         input logic [CFG_W-1:0] cfg_mid, input int mode,
                         input string req);
    exp_item_t it;
    int lat = (k > CNT_MAX) ? CNT_MAX : k;
    it.lat = lat;
    it.exc = ref_armed(cfg) && (lat > ref_thr(cfg));
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
    thr_cfg = cfg; start_evt = 1'b1; marked = 1'b1;
    @(negedge clk);
    start_evt = 1'b0; marked = 1'b0;
    check(busy == 1'b1, "R1", int'(busy), 1);
    if (mode == 3) thr_cfg = cfg_mid;
    for (int i = 1; i < k; i++) begin
      if (mode == 1 && i == k / 2) begin
        start_evt = 1'b1; marked = 1'b1;
      end else begin
        start_evt = 1'b0; marked = 1'b0;
      end
      @(negedge clk);
    end
    end_evt = 1'b1;
    if (mode == 2) begin start_evt = 1'b1; marked = 1'b1; end
    @(negedge clk);
    end_evt = 1'b0; start_evt = 1'b0; marked = 1'b0;
    check(busy == 1'b0, (mode == 2) ? "R12" : "R2", int'(busy), 0);
    @(negedge clk);
  endtask

  // Monitor: compares on every closing measurement
  initial begin : monitor
    bit prev_busy = 1'b0;
    exp_item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_busy && !busy) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2", 1, 0);
          end else begin
            it = sb.pop_front();
            check(int'(latency) == it.lat, it.req, int'(latency), it.lat);
            check(exceed == it.exc, it.req, int'(exceed), int'(it.exc));
          end
        end else if (exceed) begin
          check(1'b0, "R9", 1, 0);
        end
        prev_busy = busy;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int hold;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && exceed == 1'b0 && latency == '0, "R13",
          int'(latency) + int'(busy) + int'(exceed), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: unmarked start ignored
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1", int'(busy), 0);

    // R5/R9: threshold 256 (exp1, mant 0x40), equal then above
    measure(256, mk(1, 8'h40), '0, 0, "R9");
    measure(257, mk(1, 8'h40), '0, 0, "R5");
    measure(6, mk(0, 5), '0, 0, "R5");
    measure(5, mk(0, 5), '0, 0, "R9");
    measure(3073, mk(2, 8'hC0), '0, 0, "R5");
    // R6: exponent above limit clamps to 4080
    measure(4080, mk(7, 8'h80), '0, 0, "R6");
    measure(4081, mk(7, 8'h80), '0, 0, "R6");
    // R7: invalid mantissa, R8: zero
    measure(300, mk(1, 8'h3F), '0, 0, "R7");
    measure(10, '0, '0, 0, "R8");
    // R3: saturation
    measure(4200, mk(0, 8'hFF), '0, 0, "R3");
    // R4: start during measurement ignored
    measure(40, mk(0, 20), '0, 1, "R4");
    // R10: cfg rewritten to zero mid-run
    measure(8, mk(0, 5), '0, 3, "R10");
    // R12: start and end together while open
    measure(12, mk(0, 3), '0, 2, "R12");

    // R11: latency holds, cleared by next accepted start
    hold = int'(latency);
    repeat (5) @(negedge clk);
    check(int'(latency) == hold && hold == 12, "R11", int'(latency), 12);

    // R12: end while idle ignored
    end_evt = 1'b1; @(negedge clk); end_evt = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && int'(latency) == 12, "R12", int'(latency), 12);

    // R12: start and end together while idle -> start wins
    sb.push_back('{lat: 7, exc: 1'b1, req: "R12"});
    thr_cfg = mk(0, 2);
    start_evt = 1'b1; marked = 1'b1; end_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0; marked = 1'b0; end_evt = 1'b0;
    check(busy == 1'b1, "R12", int'(busy), 1);
    check(latency == '0, "R11", int'(latency), 0);
    repeat (6) @(negedge clk);
    end_evt = 1'b1; @(negedge clk); end_evt = 1'b0;
    repeat (2) @(negedge clk);

    check(sb.size() == 0, "R2", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule